// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a processor's read path and a slower word-addressed main memory. Each 15-bit word address is split into a set index and a tag. The index selects one of 512 sets. Every set holds two tag-data pairs, each with its own valid flag, and one replacement bit. The tag is compared against both pairs of the selected set at the same time. A match in either pair returns the stored 12-bit word on the clock after the request.

When neither pair matches, the block stops accepting requests and raises a read request to main memory. When memory answers, the word goes back to the processor and is written into the set at the same time. The new word goes into an empty pair if the set has one, trying pair 0 before pair 1. Otherwise it replaces the pair named by the set's replacement bit.

A build-time parameter selects the replacement policy. First-in-first-out evicts the pair that was filled earliest. Least-recently-used evicts the pair that was touched least recently, where both hits and fills count as a touch.

Top module: `sa2_read_cache`

## Requirements
- R1: After reset every pair of every set is invalid. `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0, and the first request to any address is a miss.
- R2: The set index is address bits [8:0] and the tag is bits [14:9]. Two addresses that share an index but differ in tag do not hit on each other.
- R3: A request accepted while `req_valid` and `req_ready` are both 1 that hits gives `rsp_valid`=1, `rsp_hit`=1 and the stored word in the next cycle, and raises no memory request.
- R4: A request that misses raises `mem_req_valid` in the next cycle, with `mem_req_addr` equal to the request address. Both stay unchanged, and `req_ready` stays 0, until the cycle in which `mem_rsp_valid` is 1.
- R5: In the cycle after `mem_rsp_valid`, `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equals the memory word. A later request to the same address then hits.
- R6: Two words with the same index can be held together. For example, octal 01000 and 02000 both stay resident in set 0, and octal 02777 and 00777 both stay resident in set 511.
- R7: A miss fills pair 0 if it is invalid, otherwise pair 1 if it is invalid. The replacement policy is used only when both pairs are valid.
- R8: With `POLICY`=FIFO, the replacement bit toggles on each fill and does not change on hits. The victim is therefore the pair filled earliest, even if that pair was hit recently.
- R9: With `POLICY`=LRU, every hit or fill points the replacement bit at the other pair. The victim is therefore the pair accessed least recently.
- R10: At most one pair of a set matches a request tag.
- R11: A fill or replacement-state update in one set does not change what hits in any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W (15) | Word address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse with the read result |
| rsp_hit | output | 1 | Result came from the cache (1) or from memory (0) |
| rsp_data | output | DATA_W (12) | Read word |
| mem_req_valid | output | 1 | Memory read request, held until answered |
| mem_req_addr | output | ADDR_W (15) | Word address sent to memory |
| mem_rsp_valid | input | 1 | One-cycle pulse, memory word available |
| mem_rsp_data | input | DATA_W (12) | Word returned by memory |

## Verification
The properties assume three things about the inputs. The processor raises `req_valid` only when it is ready to have the request taken. Memory pulses `mem_rsp_valid` for exactly one cycle and only while `mem_req_valid` is high. Memory never answers a request that was not made. The bench drives one request at a time and waits for its response before sending the next. Its memory model answers each request once, after a fixed three-cycle wait, with a word computed from the address. The FIFO and LRU builds run side by side on the same address sequence, and that sequence is arranged so that the two victim choices lead to different hit patterns.

// File: rtl/sa2_pkg.sv
package sa2_pkg;

  typedef enum logic {REPL_FIFO = 1'b0, REPL_LRU = 1'b1} repl_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_MISS = 1'b1} state_e;

  // Way to fill on a miss: empty way 0, then empty way 1, else the policy bit.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic repl);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return repl;
  endfunction

  // New replacement bit after a hit (is_fill=0) or a fill (is_fill=1) of way used_way.
  function automatic logic next_repl(input repl_e pol, input logic cur,
                                     input logic is_fill, input logic used_way);
    if (pol == REPL_FIFO) return is_fill ? ~cur : cur;
    else                  return ~used_way;
  endfunction

endpackage

// File: rtl/sa2_way_store.sv
module sa2_way_store #(
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];
endmodule

// File: rtl/sa2_tag_match.sv
module sa2_tag_match #(
  parameter int TAG_W = 6,
  parameter int WAYS  = 2
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == tag);
  end
endmodule

// File: rtl/sa2_repl_state.sv
module sa2_repl_state #(
  parameter int             IDX_W  = 9,
  parameter sa2_pkg::repl_e POLICY = sa2_pkg::REPL_FIFO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_fill,
  input  logic             upd_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] bits_q;
  logic            cur_bit;
  logic            nxt_bit;

  assign cur_bit = bits_q[upd_idx];

  if (POLICY == sa2_pkg::REPL_FIFO) begin : g_fifo
    assign nxt_bit = upd_fill ? ~cur_bit : cur_bit;
  end else begin : g_lru
    assign nxt_bit = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (upd_en) bits_q[upd_idx] <= nxt_bit;
  end

  assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/sa2_read_cache.sv
module sa2_read_cache #(
  parameter int             ADDR_W = 15,
  parameter int             DATA_W = 12,
  parameter int             IDX_W  = 9,
  parameter sa2_pkg::repl_e POLICY = sa2_pkg::REPL_FIFO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import sa2_pkg::*;

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAYS  = 2;

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              victim_q;
  logic              rsp_valid_q;
  logic              rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [IDX_W-1:0]             req_idx, fill_idx;
  logic [TAG_W-1:0]             req_tag, fill_tag;
  logic [WAYS-1:0]              way_valid;
  logic [WAYS-1:0][TAG_W-1:0]   way_tag;
  logic [WAYS-1:0][DATA_W-1:0]  way_data;
  logic [WAYS-1:0]              way_match;
  logic                         repl_bit;

  // Named events for the checker
  logic              acc;
  logic              lookup_hit;
  logic              hit_way;
  logic              fill_ev;
  logic              victim;
  logic [DATA_W-1:0] hit_data;

  assign req_idx  = req_addr[IDX_W-1:0];
  assign req_tag  = req_addr[ADDR_W-1:IDX_W];
  assign fill_idx = addr_q[IDX_W-1:0];
  assign fill_tag = addr_q[ADDR_W-1:IDX_W];

  assign req_ready  = (state_q == ST_IDLE);
  assign acc        = req_valid && req_ready;
  assign lookup_hit = |way_match;
  assign hit_way    = way_match[1];
  assign hit_data   = way_data[hit_way];
  assign fill_ev    = (state_q == ST_MISS) && mem_rsp_valid;
  assign victim     = pick_victim(way_valid[0], way_valid[1], repl_bit);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa2_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (req_idx),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .wr_en    (fill_ev && (victim_q == 1'(w))),
      .wr_idx   (fill_idx),
      .wr_tag   (fill_tag),
      .wr_data  (mem_rsp_data)
    );
  end

  sa2_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .way_valid (way_valid),
    .way_tag   (way_tag),
    .tag       (req_tag),
    .match     (way_match)
  );

  sa2_repl_state #(.IDX_W(IDX_W), .POLICY(POLICY)) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_bit   (repl_bit),
    .upd_en   ((acc && lookup_hit) || fill_ev),
    .upd_idx  (fill_ev ? fill_idx : req_idx),
    .upd_fill (fill_ev),
    .upd_way  (fill_ev ? victim_q : hit_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      victim_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= (acc && lookup_hit) || fill_ev;
      rsp_hit_q   <= acc && lookup_hit;
      if (acc && lookup_hit) rsp_data_q <= hit_data;
      else if (fill_ev)      rsp_data_q <= mem_rsp_data;
      case (state_q)
        ST_IDLE: if (acc && !lookup_hit) begin
          state_q  <= ST_MISS;
          addr_q   <= req_addr;
          victim_q <= victim;
        end
        ST_MISS: if (mem_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (state_q == ST_MISS);
  assign mem_req_addr  = addr_q;
endmodule

// File: rtl/sa2_read_cache_chk.sv
module sa2_read_cache_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data,
  input logic              acc,
  input logic              lookup_hit,
  input logic [1:0]        way_match
);
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));

  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lookup_hit) |=> (rsp_valid && rsp_hit && !mem_req_valid));

  a_r4_miss_request: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lookup_hit) |=> (mem_req_valid && !req_ready && mem_req_addr == $past(req_addr)));

  a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r5_fill_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid) |=>
      (rsp_valid && !rsp_hit && rsp_data == $past(mem_rsp_data) && !mem_req_valid));
endmodule

bind sa2_read_cache sa2_read_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_addr      (req_addr),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_data      (rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .acc           (acc),
  .lookup_hit    (lookup_hit),
  .way_match     (way_match)
);

// File: tb/sa2_read_cache_tb.sv
`timescale 1ns/1ps
module sa2_read_cache_tb;
  localparam int AW = 15;
  localparam int DW = 12;
  localparam int NV = 16;

  // {address, expected hit under FIFO, expected hit under LRU}
  localparam logic [AW+1:0] VEC [NV] = '{
    {15'o01000, 1'b0, 1'b0},  // 0  R7 way 0
    {15'o02000, 1'b0, 1'b0},  // 1  R7 way 1
    {15'o01000, 1'b1, 1'b1},  // 2  R6
    {15'o02000, 1'b1, 1'b1},  // 3  R6
    {15'o01000, 1'b1, 1'b1},  // 4  R9 touches way 0
    {15'o03000, 1'b0, 1'b0},  // 5  FIFO evicts 01000, LRU evicts 02000
    {15'o02000, 1'b1, 1'b0},  // 6  R8 / R9 divergence
    {15'o01000, 1'b0, 1'b0},  // 7
    {15'o03000, 1'b1, 1'b0},  // 8
    {15'o02777, 1'b0, 1'b0},  // 9  R6 set 511
    {15'o00777, 1'b0, 1'b0},  // 10
    {15'o02777, 1'b1, 1'b1},  // 11
    {15'o00777, 1'b1, 1'b1},  // 12
    {15'o03000, 1'b1, 1'b1},  // 13 R11 set 0 kept
    {15'o01001, 1'b0, 1'b0},  // 14 R2 other index
    {15'o01000, 1'b1, 1'b1}   // 15 R11
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;

  logic          f_ready, f_rv, f_hit, f_mrv, f_mrsp = 1'b0;
  logic [DW-1:0] f_data, f_mdata = '0;
  logic [AW-1:0] f_maddr;
  logic          l_ready, l_rv, l_hit, l_mrv, l_mrsp = 1'b0;
  logic [DW-1:0] l_data, l_mdata = '0;
  logic [AW-1:0] l_maddr;

  int nchk = 0, nfail = 0;
  int nreq_f = 0, nreq_l = 0, cnt_f = 0, cnt_l = 0;

  sa2_read_cache #(.POLICY(sa2_pkg::REPL_FIFO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(f_ready), .rsp_valid(f_rv), .rsp_hit(f_hit), .rsp_data(f_data),
    .mem_req_valid(f_mrv), .mem_req_addr(f_maddr),
    .mem_rsp_valid(f_mrsp), .mem_rsp_data(f_mdata));

  sa2_read_cache #(.POLICY(sa2_pkg::REPL_LRU)) u_dut_lru (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(l_ready), .rsp_valid(l_rv), .rsp_hit(l_hit), .rsp_data(l_data),
    .mem_req_valid(l_mrv), .mem_req_addr(l_maddr),
    .mem_rsp_valid(l_mrsp), .mem_rsp_data(l_mdata));

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [DW-1:0] m;
    m = a[11:0] * 12'd37;
    return m ^ {a[14:12], 9'd0} ^ 12'h5A3;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Memory models: answer three negedges after the request appears (R4 checks here)
  always @(negedge clk) begin
    if (f_mrsp) begin
      f_mrsp = 1'b0; cnt_f = 0;
    end else if (f_mrv) begin
      if (cnt_f == 2) begin
        check(f_maddr == req_addr, "R4 fifo mem_req_addr", f_maddr, req_addr);
        check(!f_ready, "R4 fifo req_ready low", f_ready, 0);
        f_mdata = mem_word(f_maddr); f_mrsp = 1'b1; nreq_f++;
      end else cnt_f++;
    end
  end

  always @(negedge clk) begin
    if (l_mrsp) begin
      l_mrsp = 1'b0; cnt_l = 0;
    end else if (l_mrv) begin
      if (cnt_l == 2) begin
        check(l_maddr == req_addr, "R4 lru mem_req_addr", l_maddr, req_addr);
        check(!l_ready, "R4 lru req_ready low", l_ready, 0);
        l_mdata = mem_word(l_maddr); l_mrsp = 1'b1; nreq_l++;
      end else cnt_l++;
    end
  end

  task automatic run_req(input logic [AW-1:0] a, input bit ef, input bit el, input string tag);
    int n, lf, ll, bf, bl;
    bit gf, gl, hf, hl;
    logic [DW-1:0] df, dl;
    n = 0; lf = 0; ll = 0; gf = 0; gl = 0; hf = 0; hl = 0; df = '0; dl = '0;
    @(negedge clk);
    bf = nreq_f; bl = nreq_l;
    req_valid = 1'b1; req_addr = a;
    while (!(gf && gl) && n < 60) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (f_rv && !gf) begin gf = 1; lf = n; hf = f_hit; df = f_data; end
      if (l_rv && !gl) begin gl = 1; ll = n; hl = l_hit; dl = l_data; end
    end
    check(hf == ef, {tag, " fifo hit"}, hf, ef);
    check(hl == el, {tag, " lru hit"}, hl, el);
    check(df == mem_word(a), "R3 or R5 fifo data", df, mem_word(a));
    check(dl == mem_word(a), "R3 or R5 lru data", dl, mem_word(a));
    check(lf == (ef ? 1 : 4), "R3 or R5 fifo latency", lf, ef ? 1 : 4);
    check(ll == (el ? 1 : 4), "R3 or R5 lru latency", ll, el ? 1 : 4);
    check(nreq_f - bf == (ef ? 0 : 1), "R3 or R4 fifo mem reads", nreq_f - bf, ef ? 0 : 1);
    check(nreq_l - bl == (el ? 0 : 1), "R3 or R4 lru mem reads", nreq_l - bl, el ? 0 : 1);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(f_ready && l_ready, "R1 req_ready after reset", f_ready, 1);
    check(!f_rv && !l_rv, "R1 rsp_valid after reset", f_rv, 0);
    check(!f_mrv && !l_mrv, "R1 mem_req_valid after reset", f_mrv, 0);

    for (int i = 0; i < NV; i++) begin
      string t;
      case (i)
        0, 1:          t = "R7";
        2, 3, 9, 10, 11, 12: t = "R6";
        4, 5, 6, 7, 8: t = "R8 and R9";
        14:            t = "R2";
        default:       t = "R11";
      endcase
      run_req(VEC[i][AW+1:2], VEC[i][1], VEC[i][0], t);
    end

    // R2: same index as resident lines, new tag, must miss
    run_req(15'o07000, 1'b0, 1'b0, "R2 tag differs");
    // R5: the word just filled now hits
    run_req(15'o07000, 1'b1, 1'b1, "R5 refill hit");

    // R1: reset clears all lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(f_ready && !f_rv && !f_mrv, "R1 fifo idle after reset", f_ready, 1);
    run_req(15'o00777, 1'b0, 1'b0, "R1 miss after reset");
    run_req(15'o00777, 1'b1, 1'b1, "R7 refill after reset");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule